// File: doc/BRIEF.md
# Gated 13-Bit Timer/Counter

This block is one timer/counter channel fixed in a 13-bit counting mode. The count is held in two bytes. The whole high byte forms the upper eight bits, and the low five bits of the low byte form the lower part. Seen from outside, the low five bits act as a divide-by-32 prescaler in front of an 8-bit counter. Each count event adds one. When the count wraps from all ones to zero, the block raises an overflow flag.

A source bit picks what drives the count. In timer mode the source is a tick made by dividing the clock by six. In counter mode it is the falling edges of an external pin, which is synchronized first. Counting is allowed only while the run bit is set and the gate condition is met. The gate condition holds when the gate bit is clear or the synchronized gate pin is high. Software sets the mode, loads and reads the two count bytes, and clears the flag over a small register bus. The flag is also cleared by an acknowledge pulse when the timer's interrupt is taken.

Top module: `tmr13_unit`

## Requirements
- R1: After a synchronous reset, the control register, both count bytes, the read data and the overflow flag are all zero.
- R2: The count is `{high[7:0], low[4:0]}`. When the low five bits wrap from 31 to 0, the high byte advances by one.
- R3: In timer mode (control bit 2 = 0), while counting is allowed, the count advances by exactly one every 6 clock cycles.
- R4: An increment from 0x1FFF gives a count of 0 and sets the overflow flag.
- R5: Counting is allowed only when the run bit (control bit 0) is 1 and either the gate bit (control bit 1) is 0 or the synchronized gate pin is high.
- R6: In counter mode (control bit 2 = 1), the count advances once for each falling edge of the synchronized count pin. The pin is sampled on the divide-by-6 tick. The internal tick alone does not advance the count.
- R7: Writing the run bit leaves the count unchanged. Stopping and restarting continues from the held value.
- R8: The flag (control bit 3) is cleared by a one-cycle high pulse on `vec_ack`, or by a control write with bit 3 = 0. A control write with bit 3 = 1 leaves the flag unchanged.
- R9: Bits 7:5 of the low byte take no part in counting. Whatever is written there does not change the count or its carries.
- R10: A count-byte write in a cycle where an increment is due wins. The written value is stored and no increment happens in that cycle.
- R11: If an overflow and a flag clear fall in the same cycle, the flag ends up set.
- R12: Reads are registered: `bus_rdata` shows, one cycle later, the register selected by `bus_addr` (0 control, 1 low byte, 2 high byte, 3 reads zero). Control reads as {4'b0, flag, source, gate, run}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cnt_pin | input | 1 | External count input (asynchronous) |
| gate_pin | input | 1 | External gate input (asynchronous) |
| vec_ack | input | 1 | Interrupt-taken pulse that clears the flag |
| ovf_flag | output | 1 | Overflow flag |

## Verification
Two pairs of actions can fall in the same cycle: an overflow increment with a flag clear, and a count increment with a software write to a count byte. The bench first finds the phase of the divide-by-6 tick by timing when the flag first rises. It then places an acknowledge pulse exactly on a wrapping tick, and a low-byte write exactly on a counting tick. In the first case the flag must read back as set and the count as zero. In the second case the low byte must hold the written value and must not be one higher.

// File: rtl/tmr13_pkg.sv
`timescale 1ns/1ps
package tmr13_pkg;
  localparam int unsigned BUS_AW = 2;

  typedef enum logic [BUS_AW-1:0] {
    REG_CTRL = 2'd0,
    REG_LOW  = 2'd1,
    REG_HIGH = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_GATE = 1;
  localparam int unsigned CB_SRC  = 2;
  localparam int unsigned CB_FLAG = 3;

  typedef struct packed {
    logic src_ext;
    logic gate_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr13_sync.sv
`timescale 1ns/1ps
module tmr13_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{RST_VAL}};
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tmr13_tick.sv
`timescale 1ns/1ps
module tmr13_tick #(
  parameter int unsigned DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (div_q == LAST);
      div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr13_src.sv
`timescale 1ns/1ps
module tmr13_src (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic src_ext_i,
  input  logic pin_s_i,
  input  logic allow_i,
  output logic inc_o
);
  logic smp_q;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst)         smp_q <= 1'b0;
    else if (tick_i) smp_q <= pin_s_i;
  end

  assign fall  = smp_q & ~pin_s_i;
  assign inc_o = tick_i & allow_i & (src_ext_i ? fall : 1'b1);
endmodule

// File: rtl/tmr13_core.sv
`timescale 1ns/1ps
module tmr13_core #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LO_W   = 5,
  parameter int unsigned HI_W   = 8,
  localparam int unsigned CW    = LO_W + HI_W,
  localparam int unsigned PAD_W = DATA_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              flag_wr_i,
  input  logic              flag_bit_i,
  output logic [LO_W-1:0]   lo_o,
  output logic [PAD_W-1:0]  pad_o,
  output logic [HI_W-1:0]   hi_o,
  output logic              flag_o,
  output logic [CW-1:0]     count_o,
  output logic              cnt_wr_o,
  output logic              ovf_set_o
);
  logic [CW-1:0] nxt;
  logic          flag_clr;

  assign count_o   = {hi_o, lo_o};
  assign nxt       = count_o + 1'b1;
  assign cnt_wr_o  = wr_lo_i | wr_hi_i;
  assign ovf_set_o = inc_i & ~cnt_wr_o & (&count_o);
  assign flag_clr  = ack_i | (flag_wr_i & ~flag_bit_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_o  <= '0;
      pad_o <= '0;
      hi_o  <= '0;
    end else if (cnt_wr_o) begin
      if (wr_lo_i) {pad_o, lo_o} <= wdata_i;
      if (wr_hi_i) hi_o <= wdata_i[HI_W-1:0];
    end else if (inc_i) begin
      {hi_o, lo_o} <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            flag_o <= 1'b0;
    else if (ovf_set_o) flag_o <= 1'b1;
    else if (flag_clr)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/tmr13_unit.sv
`timescale 1ns/1ps
module tmr13_unit #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LO_W   = 5,
  parameter int unsigned HI_W   = 8,
  parameter int unsigned DIV    = 6,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              vec_ack,
  output logic              ovf_flag
);
  import tmr13_pkg::*;

  localparam int unsigned CW    = LO_W + HI_W;
  localparam int unsigned PAD_W = DATA_W - LO_W;

  reg_sel_e          sel;
  ctrl_t             ctrl_q;
  logic              wr_ctrl, wr_lo, wr_hi;
  logic              gate_s, pin_s, tick, allow, inc_evt;
  logic              run_bit, cnt_wr, ovf_set;
  logic [LO_W-1:0]   lo_q;
  logic [PAD_W-1:0]  pad_q;
  logic [HI_W-1:0]   hi_q;
  logic [CW-1:0]     count_val;
  logic [DATA_W-1:0] ctrl_rd;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_wr & (sel == REG_CTRL);
  assign wr_lo   = bus_wr & (sel == REG_LOW);
  assign wr_hi   = bus_wr & (sel == REG_HIGH);
  assign run_bit = ctrl_q.run;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.run     <= bus_wdata[CB_RUN];
      ctrl_q.gate_en <= bus_wdata[CB_GATE];
      ctrl_q.src_ext <= bus_wdata[CB_SRC];
    end
  end

  tmr13_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_gate_sync (
    .clk(clk), .rst(rst), .d_i(gate_pin), .q_o(gate_s));

  tmr13_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst(rst), .d_i(cnt_pin), .q_o(pin_s));

  tmr13_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick));

  assign allow = ctrl_q.run & (~ctrl_q.gate_en | gate_s);

  tmr13_src u_src (
    .clk(clk), .rst(rst), .tick_i(tick), .src_ext_i(ctrl_q.src_ext),
    .pin_s_i(pin_s), .allow_i(allow), .inc_o(inc_evt));

  tmr13_core #(.DATA_W(DATA_W), .LO_W(LO_W), .HI_W(HI_W)) u_core (
    .clk(clk), .rst(rst), .inc_i(inc_evt), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(bus_wdata), .ack_i(vec_ack), .flag_wr_i(wr_ctrl),
    .flag_bit_i(bus_wdata[CB_FLAG]), .lo_o(lo_q), .pad_o(pad_q), .hi_o(hi_q),
    .flag_o(ovf_flag), .count_o(count_val), .cnt_wr_o(cnt_wr),
    .ovf_set_o(ovf_set));

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_RUN]  = ctrl_q.run;
    ctrl_rd[CB_GATE] = ctrl_q.gate_en;
    ctrl_rd[CB_SRC]  = ctrl_q.src_ext;
    ctrl_rd[CB_FLAG] = ovf_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (sel)
        REG_CTRL: bus_rdata <= ctrl_rd;
        REG_LOW:  bus_rdata <= {pad_q, lo_q};
        REG_HIGH: bus_rdata <= DATA_W'(hi_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr13_unit_chk.sv
`timescale 1ns/1ps
module tmr13_unit_chk #(
  parameter int unsigned CW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          vec_ack,
  input logic          ovf_flag,
  input logic          run_bit,
  input logic          inc_evt,
  input logic          cnt_wr,
  input logic          ovf_set,
  input logic [CW-1:0] count_val
);
  localparam logic [CW-1:0] CMAX = '1;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (count_val == '0) && !ovf_flag);

  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    inc_evt && !cnt_wr |=> count_val == CW'($past(count_val) + 1'b1));

  a_r4_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    inc_evt && !cnt_wr && (count_val == CMAX) |=> (count_val == '0) && ovf_flag);

  a_r5_no_run: assert property (@(posedge clk) disable iff (rst)
    !run_bit |-> !inc_evt);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !inc_evt && !cnt_wr |=> $stable(count_val));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    vec_ack && !ovf_set |=> !ovf_flag);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    ovf_set && vec_ack |=> ovf_flag);
endmodule

bind tmr13_unit tmr13_unit_chk #(.CW(LO_W + HI_W)) u_chk (
  .clk(clk), .rst(rst), .vec_ack(vec_ack), .ovf_flag(ovf_flag),
  .run_bit(run_bit), .inc_evt(inc_evt), .cnt_wr(cnt_wr),
  .ovf_set(ovf_set), .count_val(count_val));

// File: tb/tmr13_unit_bench.sv
`timescale 1ns/1ps
module tmr13_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cnt_pin = 1'b0;
  logic       gate_pin = 1'b0;
  logic       vec_ack = 1'b0;
  logic       ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ph = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr13_unit u_tmr13_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .vec_ack(vec_ack), .ovf_flag(ovf_flag));

  typedef struct packed {
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] edges;
    logic [7:0]  ehi;
    logic [4:0]  elo;
    logic        eflag;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 16'd600, 8'h03, 5'h04, 1'b0},
    '{8'h00, 8'h1F, 16'd6,   8'h01, 5'h00, 1'b0},
    '{8'hFF, 8'h1F, 16'd6,   8'h00, 5'h00, 1'b1},
    '{8'h7F, 8'hFF, 16'd6,   8'h80, 5'h00, 1'b0},
    '{8'hFF, 8'h1E, 16'd60,  8'h00, 5'h08, 1'b1},
    '{8'h12, 8'hE3, 16'd192, 8'h13, 5'h03, 1'b0}
  };

  localparam logic [1:0] A_CTRL = 2'd0, A_LO = 2'd1, A_HI = 2'd2, A_NONE = 2'd3;
  localparam logic [7:0] C_STOP = 8'h08, C_RUN = 8'h09, C_CLR = 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic preset(input logic [7:0] h, input logic [7:0] l);
    wr(A_CTRL, C_CLR);
    wr(A_HI, h);
    wr(A_LO, l);
  endtask

  task automatic run_for(input int edges, input logic [7:0] runc);
    wr(A_CTRL, runc);
    repeat (edges - 1) @(posedge clk);
    wr(A_CTRL, C_STOP);
  endtask

  task automatic check_count(input logic [7:0] eh, input logic [4:0] el, input string req);
    logic [7:0] h, l;
    rd(A_HI, h);
    rd(A_LO, l);
    chk(h == eh, req, h, eh);
    chk(l[4:0] == el, req, l[4:0], el);
  endtask

  task automatic wait_pre_tick();
    do @(negedge clk); while (((cyc + 1) % 6) != ph);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1, R12: reset state
    chk(ovf_flag == 1'b0, "R1 flag", ovf_flag, 0);
    rd(A_CTRL, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(A_LO, v);   chk(v == 8'h00, "R1 low", v, 0);
    rd(A_HI, v);   chk(v == 8'h00, "R1 high", v, 0);

    // R12: control readback, unused address
    wr(A_CTRL, 8'h06);
    rd(A_CTRL, v); chk(v == 8'h06, "R12 ctrl readback", v, 8'h06);
    rd(A_NONE, v); chk(v == 8'h00, "R12 addr 3", v, 0);
    wr(A_CTRL, C_CLR);

    // R2, R3, R4, R9: vector table
    for (int i = 0; i < NV; i++) begin
      preset(VECS[i].hi, VECS[i].lo);
      run_for(int'(VECS[i].edges), C_RUN);
      check_count(VECS[i].ehi, VECS[i].elo, "R2/R3/R9 table count");
      chk(ovf_flag == VECS[i].eflag, "R4 table flag", ovf_flag, VECS[i].eflag);
    end

    // R5: gate low blocks, gate high allows
    gate_pin = 1'b0;
    preset(8'h00, 8'h00);
    run_for(600, 8'h0B);
    check_count(8'h00, 5'h00, "R5 gate low");
    gate_pin = 1'b1;
    repeat (5) @(negedge clk);
    run_for(600, 8'h0B);
    check_count(8'h03, 5'h04, "R5 gate high");
    // R5: run bit clear blocks counting
    preset(8'h00, 8'h00);
    repeat (120) @(negedge clk);
    check_count(8'h00, 5'h00, "R5 run clear");

    // R6: counter mode ignores the tick, counts pin falls
    preset(8'h00, 8'h00);
    cnt_pin = 1'b0;
    run_for(600, 8'h0D);
    check_count(8'h00, 5'h00, "R6 no pin edges");
    wr(A_CTRL, 8'h0D);
    for (int p = 0; p < 10; p++) begin
      cnt_pin = 1'b1; repeat (12) @(negedge clk);
      cnt_pin = 1'b0; repeat (12) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    wr(A_CTRL, C_STOP);
    check_count(8'h00, 5'h0A, "R6 ten falls");

    // R7: restart continues from held count
    preset(8'h00, 8'h05);
    run_for(60, C_RUN);
    check_count(8'h00, 5'h0F, "R7 first run");
    run_for(60, C_RUN);
    check_count(8'h00, 5'h19, "R7 resumed");

    // R8: flag set, write 1 keeps, ack clears, write 0 clears
    preset(8'hFF, 8'h1F);
    run_for(6, C_RUN);
    chk(ovf_flag == 1'b1, "R8 flag set", ovf_flag, 1);
    wr(A_CTRL, C_STOP);
    chk(ovf_flag == 1'b1, "R8 write one keeps", ovf_flag, 1);
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
    chk(ovf_flag == 1'b0, "R8 ack clears", ovf_flag, 0);
    preset(8'hFF, 8'h1F);
    run_for(6, C_RUN);
    wr(A_CTRL, C_CLR);
    chk(ovf_flag == 1'b0, "R8 write zero clears", ovf_flag, 0);

    // Find the tick phase from the first flag rise
    preset(8'hFF, 8'h1F);
    wr(A_CTRL, C_RUN);
    for (int k = 0; k < 20; k++) begin
      if (ovf_flag) begin ph = cyc % 6; break; end
      @(negedge clk);
    end
    wr(A_CTRL, C_CLR);

    // R11: ack on the wrapping tick, set wins
    preset(8'hFF, 8'h1F);
    wr(A_CTRL, C_RUN);
    wait_pre_tick();
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
    bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = C_STOP;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(ovf_flag == 1'b1, "R11 set beats ack", ovf_flag, 1);
    check_count(8'h00, 5'h00, "R11 wrapped count");

    // R10: low-byte write on a counting tick wins
    preset(8'h00, 8'h00);
    wr(A_CTRL, C_RUN);
    wait_pre_tick();
    bus_wr = 1'b1; bus_addr = A_LO; bus_wdata = 8'h0A;
    @(negedge clk);
    bus_addr = A_CTRL; bus_wdata = C_STOP;
    @(negedge clk);
    bus_wr = 1'b0;
    check_count(8'h00, 5'h0A, "R10 write beats increment");

    finish_run();
  end
endmodule